// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Empty and Near-Full Thresholds

This block is a first-in first-out buffer for 9-bit words. The producer side and the consumer side each have their own clock, and the two clocks may run independently or be tied together. Each side qualifies its transfers with a pair of enable inputs. The pointers cross between the domains as Gray code through synchronizer chains. For that reason every status flag is conservative: it may report less data (or less space) than is really there, but never more.

Four active-low status outputs are driven, each registered in the domain of the side that consumes it. On the consumer side these are empty and near-empty. On the producer side they are full and near-full. The two near thresholds are offsets, loaded one word at a time by a neighbouring block through a load strobe in the matching clock domain. Both offsets come out of reset at seven words. Read data leaves through a registered port that an active-low output enable can float.

Top module: `dcf_fifo`

## Requirements
- R1: A word is stored on a rising `wclk` edge only when `wr_en1_n` is 0, `wr_en2` is 1 and `full_n` is 1. The other three combinations of the two write enables store nothing.
- R2: A read takes place on a rising `rclk` edge only when `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1. At that same edge the output register loads the oldest stored word. The register holds its value on every other edge, so words leave in the order they were written.
- R3: A write attempted while `full_n` is 0 and a read attempted while `empty_n` is 0 change neither the pointers nor the stored data.
- R4: `empty_n` is registered on `rclk`. After each edge it is 0 exactly when the read count equals the write count that the read side can see through the 2-stage synchronizer. With tied clocks, this is the write count as of three edges earlier. A first word written at edge E therefore raises `empty_n` after edge E+3 and can be read at edge E+4.
- R5: `full_n` is registered on `wclk`. After each edge it is 0 exactly when the write count minus the synchronized read count equals DEPTH (2**ADDR_W). With tied clocks, the synchronized read count is the read count as of three edges earlier.
- R6: `aempty_n` is registered on `rclk` and is 0 when (synchronized write count − read count) ≤ the near-empty offset.
- R7: `afull_n` is registered on `wclk` and is 0 when (write count − synchronized read count) ≥ DEPTH − the near-full offset.
- R8: `rst_n` is active low and is sampled on both clocks. While it is 0, both pointers and all synchronizer stages clear, the read register clears to 0, both offsets return to 7, `empty_n` and `aempty_n` are 0, and `full_n` and `afull_n` are 1.
- R9: When `ae_load` is 1 at an `rclk` edge, the near-empty offset takes `ae_value` (0 to DEPTH−1). When `af_load` is 1 at a `wclk` edge, the near-full offset takes `af_value`. A new offset is used from the flag evaluation at the next edge.
- R10: While `oe_n` is 1, `rd_data` is high impedance. The output enable does not affect reads, pointers or stored data, so the register value shows again once `oe_n` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| rclk | input | 1 | Consumer clock |
| rst_n | input | 1 | Active-low reset, sampled on both clocks |
| wr_en1_n | input | 1 | Write enable, active low |
| wr_en2 | input | 1 | Write enable, active high |
| wr_data | input | DATA_W | Word to store |
| af_load | input | 1 | Load strobe for the near-full offset (wclk) |
| af_value | input | ADDR_W | Near-full offset value |
| full_n | output | 1 | Full flag, active low |
| afull_n | output | 1 | Near-full flag, active low |
| rd_en1_n | input | 1 | Read enable, active low |
| rd_en2_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable for rd_data, active low |
| ae_load | input | 1 | Load strobe for the near-empty offset (rclk) |
| ae_value | input | ADDR_W | Near-empty offset value |
| rd_data | output | DATA_W | Registered read word, tristate |
| empty_n | output | 1 | Empty flag, active low |
| aempty_n | output | 1 | Near-empty flag, active low |

## Verification
A write and a read can land on the same edge. Each moves one pointer while the other pointer's stale copy drives the flags, so the two can disagree right at the one-word, full and threshold boundaries. The bench runs with the clocks tied. It drives both ports at once, both in directed fills and drains that stop at those boundaries and in a long sweep of pseudo-random enable patterns, offset loads and output-enable toggles. It judges every edge against an arithmetic model that keeps the read and write counts of the last four edges. From those counts the model derives all four flags with the three-edge view lag, and it keeps the data order in a shadow array.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Reset value of both threshold offsets, in words.
  localparam int unsigned DCF_DEFAULT_OFFSET = 7;

  // A boundary flag paired with its programmable near flag, both active low.
  typedef struct packed {
    logic edge_n;
    logic near_n;
  } dcf_flags_t;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: plain synchronous write, block-RAM friendly.
  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read port with output register; resettable like a RAM output latch.
  always_ff @(posedge rclk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // R2: the output register only moves on an accepted read.
  p_hold_q_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              off_load,
  input  logic [ADDR_W-1:0] off_value,
  input  logic [ADDR_W:0]   rgray_async,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic              wr_ok,
  output dcf_flags_t        flags
);

  localparam int unsigned PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};

  logic [PW-1:0]     wbin, wbin_nx, wgray_nx;
  logic [PW-1:0]     rgray_s, rbin_s;
  logic [PW-1:0]     occ_nx, thr;
  logic [ADDR_W-1:0] af_off;

  dcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rsync (
    .clk(wclk), .rst_n(rst_n), .d(rgray_async), .q(rgray_s)
  );

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign rbin_s[i] = ^rgray_s[PW-1:i];
  end

  assign wr_ok    = !en1_n && en2 && flags.edge_n;
  assign wbin_nx  = wbin + PW'(wr_ok);
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign occ_nx   = wbin_nx - rbin_s;
  assign thr      = DEPTH_V - {1'b0, af_off};
  assign waddr    = wbin[ADDR_W-1:0];

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      wbin         <= '0;
      wgray        <= '0;
      flags.edge_n <= 1'b1;
      flags.near_n <= 1'b1;
      af_off       <= ADDR_W'(DCF_DEFAULT_OFFSET);
    end else begin
      wbin         <= wbin_nx;
      wgray        <= wgray_nx;
      flags.edge_n <= !(occ_nx == DEPTH_V);
      flags.near_n <= !(occ_nx >= thr);
      if (off_load) af_off <= off_value;
    end
  end

  // R3: no pointer movement while full.
  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    !flags.edge_n |=> $stable(wbin));

  // R7: full always implies near-full.
  p_full_is_afull_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    !flags.edge_n |-> !flags.near_n);

  // R5: the crossing pointer changes by at most one bit per edge.
  p_gray_step_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              en1_n,
  input  logic              en2_n,
  input  logic              off_load,
  input  logic [ADDR_W-1:0] off_value,
  input  logic [ADDR_W:0]   wgray_async,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              rd_ok,
  output dcf_flags_t        flags
);

  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0]     rbin, rbin_nx, rgray_nx;
  logic [PW-1:0]     wgray_s, wbin_s, occ_nx;
  logic [ADDR_W-1:0] ae_off;

  dcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(rclk), .rst_n(rst_n), .d(wgray_async), .q(wgray_s)
  );

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign wbin_s[i] = ^wgray_s[PW-1:i];
  end

  assign rd_ok    = !en1_n && !en2_n && flags.edge_n;
  assign rbin_nx  = rbin + PW'(rd_ok);
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign occ_nx   = wbin_s - rbin_nx;
  assign raddr    = rbin[ADDR_W-1:0];

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin         <= '0;
      rgray        <= '0;
      flags.edge_n <= 1'b0;
      flags.near_n <= 1'b0;
      ae_off       <= ADDR_W'(DCF_DEFAULT_OFFSET);
    end else begin
      rbin         <= rbin_nx;
      rgray        <= rgray_nx;
      flags.edge_n <= !(occ_nx == '0);
      flags.near_n <= !(occ_nx <= {1'b0, ae_off});
      if (off_load) ae_off <= off_value;
    end
  end

  // R3: no pointer movement while empty.
  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    !flags.edge_n |=> $stable(rbin));

  // R6: empty always implies near-empty.
  p_empty_is_aempty_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    !flags.edge_n |-> !flags.near_n);

  // R4: the crossing pointer changes by at most one bit per edge.
  p_gray_step_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned DATA_W      = 9,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wr_en1_n,
  input  logic              wr_en2,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              af_load,
  input  logic [ADDR_W-1:0] af_value,
  output logic              full_n,
  output logic              afull_n,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              oe_n,
  input  logic              ae_load,
  input  logic [ADDR_W-1:0] ae_value,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              aempty_n
);

  logic [ADDR_W-1:0] waddr, raddr;
  logic [ADDR_W:0]   wgray, rgray;
  logic              wr_ok, rd_ok;
  logic [DATA_W-1:0] q;
  dcf_flags_t        wflags, rflags;

  dcf_wr_ctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .en1_n(wr_en1_n), .en2(wr_en2),
    .off_load(af_load), .off_value(af_value), .rgray_async(rgray),
    .waddr(waddr), .wgray(wgray), .wr_ok(wr_ok), .flags(wflags)
  );

  dcf_rd_ctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
    .off_load(ae_load), .off_value(ae_value), .wgray_async(wgray),
    .raddr(raddr), .rgray(rgray), .rd_ok(rd_ok), .flags(rflags)
  );

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rst_n(rst_n), .re(rd_ok), .raddr(raddr), .rdata(q)
  );

  assign full_n   = wflags.edge_n;
  assign afull_n  = wflags.near_n;
  assign empty_n  = rflags.edge_n;
  assign aempty_n = rflags.near_n;
  assign rd_data  = oe_n ? {DATA_W{1'bz}} : q;

endmodule

// File: tb/test_dcf_fifo.sv
`timescale 1ns/1ps
module test_dcf_fifo;

  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en1_n = 1'b1, wr_en2 = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic af_load = 1'b0, ae_load = 1'b0;
  logic [AW-1:0] af_value = '0, ae_value = '0;
  logic rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
  wire  full_n, afull_n, empty_n, aempty_n;
  wire  [DW-1:0] rd_data;

  always #4 clk = ~clk;

  dcf_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) i_dcf_fifo (
    .wclk(clk), .rclk(clk), .rst_n(rst_n),
    .wr_en1_n(wr_en1_n), .wr_en2(wr_en2), .wr_data(wr_data),
    .af_load(af_load), .af_value(af_value), .full_n(full_n), .afull_n(afull_n),
    .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n),
    .ae_load(ae_load), .ae_value(ae_value), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // Model: write/read counts after the last four edges (index 0 = newest).
  int w0, w1, w2, w3, r0, r1, r2, r3;
  int m_ae_off, m_af_off;
  logic m_empty_n, m_aempty_n, m_full_n, m_afull_n;
  logic [DW-1:0] m_q;
  logic [DW-1:0] shadow [DEPTH];

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_outputs(input string ctx);
    chk({ctx, " R4 empty_n"}, DW'(empty_n), DW'(m_empty_n));
    chk({ctx, " R6 aempty_n"}, DW'(aempty_n), DW'(m_aempty_n));
    chk({ctx, " R5 full_n"}, DW'(full_n), DW'(m_full_n));
    chk({ctx, " R7 afull_n"}, DW'(afull_n), DW'(m_afull_n));
    if (!oe_n) chk({ctx, " R2 rd_data"}, rd_data, m_q);
    else       chk({ctx, " R10 float"}, rd_data, {DW{1'bz}});
  endtask

  // Called at a negedge with inputs already driven; returns at the next negedge.
  task automatic tick(input string ctx);
    bit wacc, racc;
    int occ_r, occ_w;
    @(posedge clk);
    wacc = !wr_en1_n && wr_en2 && m_full_n;        // R1
    racc = !rd_en1_n && !rd_en2_n && m_empty_n;    // R2, R3
    if (racc) m_q = shadow[r0 % DEPTH];
    if (wacc) shadow[w0 % DEPTH] = wr_data;
    w3 = w2; w2 = w1; w1 = w0; w0 = w0 + int'(wacc);
    r3 = r2; r2 = r1; r1 = r0; r0 = r0 + int'(racc);
    occ_r = w3 - r0;
    occ_w = w0 - r3;
    m_empty_n  = (occ_r != 0);
    m_aempty_n = !(occ_r <= m_ae_off);
    m_full_n   = (occ_w != DEPTH);
    m_afull_n  = !(occ_w >= DEPTH - m_af_off);
    if (ae_load) m_ae_off = int'(ae_value);        // R9
    if (af_load) m_af_off = int'(af_value);
    @(negedge clk);
    check_outputs(ctx);
  endtask

  task automatic idle();
    wr_en1_n = 1'b1; wr_en2 = 1'b0; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    ae_load = 1'b0; af_load = 1'b0; oe_n = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    w0 = 0; w1 = 0; w2 = 0; w3 = 0; r0 = 0; r1 = 0; r2 = 0; r3 = 0;
    m_ae_off = 7; m_af_off = 7;
    m_empty_n = 1'b0; m_aempty_n = 1'b0; m_full_n = 1'b1; m_afull_n = 1'b1;
    m_q = '0;
    @(negedge clk);
    check_outputs("R8 reset");
    rst_n = 1'b1;
  endtask

  task automatic run(input int n, input bit wr, input bit rd, input string ctx);
    for (int i = 0; i < n; i++) begin
      wr_en1_n = !wr; wr_en2 = wr; rd_en1_n = !rd; rd_en2_n = !rd;
      wr_data = DW'($urandom);
      tick(ctx);
    end
    idle();
  endtask

  task automatic load_offsets(input int ae, input int af);
    ae_load = 1'b1; ae_value = AW'(ae); af_load = 1'b1; af_value = AW'(af);
    tick("R9 load");
    ae_load = 1'b0; af_load = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(13));
    do_reset();

    // R1: every write-enable pair, only {en1_n=0,en2=1} stores.
    for (int c = 0; c < 4; c++) begin
      wr_en1_n = c[1]; wr_en2 = c[0];
      for (int k = 0; k < 3; k++) begin wr_data = DW'(c * 16 + k); tick("R1 enable pair"); end
    end
    idle();
    run(4, 0, 0, "R4 first-word lag");
    // R2: every read-enable pair.
    for (int c = 0; c < 4; c++) begin
      rd_en1_n = c[1]; rd_en2_n = c[0];
      for (int k = 0; k < 3; k++) tick("R2 enable pair");
    end
    idle();

    // R3: overfill then overdrain, both ends held past the boundary.
    run(DEPTH + 8, 1, 0, "R3 overfill");
    run(DEPTH + 8, 0, 1, "R3 overdrain");

    // Simultaneous read and write at the one-word and near-full levels.
    run(1, 1, 0, "R4 one word");
    run(10, 1, 1, "R4 rw one word");
    run(DEPTH, 1, 0, "R5 fill");
    run(10, 1, 1, "R5 rw full");
    run(DEPTH + 4, 0, 1, "R6 drain");

    // R9: threshold sweeps, including the extreme offsets.
    for (int t = 0; t < 4; t++) begin
      int ae, af;
      ae = (t == 0) ? 3 : (t == 1) ? 0 : (t == 2) ? DEPTH - 1 : 5;
      af = (t == 0) ? 2 : (t == 1) ? 0 : (t == 2) ? DEPTH - 1 : 11;
      load_offsets(ae, af);
      run(DEPTH + 4, 1, 0, "R7 threshold fill");
      run(DEPTH + 4, 0, 1, "R6 threshold drain");
    end

    // R8: reset mid-flight restores defaults.
    run(9, 1, 0, "R8 pre-reset fill");
    do_reset();
    run(DEPTH + 2, 1, 0, "R8 default af");
    run(DEPTH + 2, 0, 1, "R8 default ae");

    // R10: output enable toggled while reading.
    run(8, 1, 0, "R10 fill");
    for (int i = 0; i < 16; i++) begin
      oe_n = (i % 3 == 1);
      rd_en1_n = (i % 2); rd_en2_n = 1'b0;
      tick("R10 oe toggle");
    end
    idle();
    tick("R10 oe restored");

    // Sweep: pseudo-random enables, data, loads and output enable.
    for (int i = 0; i < 6000; i++) begin
      int bias;
      bias = (i / 500) % 3;
      wr_en1_n = ($urandom % 4) == 0;
      wr_en2   = ($urandom % 8) < ((bias == 1) ? 7 : 4);
      rd_en1_n = ($urandom % 4) == 0;
      rd_en2_n = ($urandom % 8) >= ((bias == 2) ? 7 : 4);
      wr_data  = DW'($urandom);
      oe_n     = ($urandom % 16) == 0;
      ae_load  = ($urandom % 64) == 0; ae_value = AW'($urandom);
      af_load  = ($urandom % 64) == 0; af_value = AW'($urandom);
      tick("R1 R2 R3 sweep");
    end
    idle();
    run(DEPTH + 4, 0, 1, "R3 sweep drain");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule